// File: doc/BRIEF.md
# Priority-Masked Software Interrupt Register

This block holds a 17-bit software interrupt register and turns it into a vector of pending interrupt requests. Each set bit is a request. A 4-bit processor interrupt level masks the requests before they leave the block. The low-order bit and the top bit (bit 16) share one fixed rule: they pass while the level is below 14. Each middle bit passes only when its own index is strictly above the level.

Software changes the register in three ways:

- A direct write replaces the whole value.
- A set alias ORs the written bits in.
- A clear alias removes the written bits.

A timer comparison unit outside the block can raise bit 16 with a one-cycle pulse. That pulse is merged with any software write in the same cycle.

The level and the register are both held in flops. The pending vector is also registered. It therefore reflects the register and level that take effect on the same clock edge. A read returns the stored register value without masking.

Top module: `softint_pil_unit`

## Requirements
- R1: After a synchronous active-low reset, the register, the level, the pending vector and the any-pending flag are all zero.
- R2: A direct write replaces the register with `wr_data` on the next edge. When more than one software write is asserted in a cycle, the direct write wins.
- R3: A set-alias write (with no direct or clear write in that cycle) makes the new value the old value ORed with `wr_data`.
- R4: A clear-alias write (with no direct write in that cycle) makes the new value the old value ANDed with the inverse of `wr_data`. It takes priority over a simultaneous set-alias write.
- R5: A `tick_set` pulse forces bit 16 to 1 on the next edge. It is ORed in after any software write in the same cycle, so it wins over a clear of bit 16 and over a direct write of 0.
- R6: Pending bits 0 and 16 are 1 only when the matching register bit is 1 and the level is less than 14.
- R7: For n from 1 to 15, pending bit n is 1 only when register bit n is 1 and n is strictly greater than the level.
- R8: A level write loads `pil_data` on the next edge, and the level is readable on `pil_value`. The pending vector is re-evaluated against the new level on that same edge.
- R9: The pending vector is registered and changes on the edge that commits the write causing the change. The any-pending flag is 1 exactly when some pending bit is 1.
- R10: `rd_value` always shows the stored register, unmasked by the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_direct | input | 1 | Direct write strobe |
| wr_set | input | 1 | Set-alias write strobe |
| wr_clr | input | 1 | Clear-alias write strobe |
| wr_data | input | 17 | Data for the software write ports |
| tick_set | input | 1 | One-cycle pulse that sets bit 16 |
| pil_wr | input | 1 | Level write strobe |
| pil_data | input | 4 | New interrupt level |
| rd_value | output | 17 | Stored register value |
| pil_value | output | 4 | Current interrupt level |
| pend | output | 17 | Masked pending requests |
| any_pend | output | 1 | OR of all pending bits |

## Verification
The directed phases cover each write kind on its own:

- A direct write of a mixed pattern separates replacement from merging.
- Set and clear aliases applied over a known non-zero value show OR and AND-NOT behaviour against old bits.
- A sweep of the level from 0 to 15 with all bits set separates the fixed threshold at 14 used by bits 0 and 16 from the per-index compare used by bits 1 to 15. The off-by-one at n equal to the level shows up here.

Coinciding strobes show the ordering between writes:

- Clear plus tick pulse, and direct zero plus tick pulse, check the ordering of bit 16.
- All three software strobes together check the direct-clear-set priority.

A long random phase with every strobe and the level changing is then compared against a behavioural model on every cycle.

// File: rtl/softint_pkg.sv
// Package: shared sizes and helpers for the masked software interrupt unit.
// Assumes a single clock domain; nothing here holds state.
package softint_pkg;
    localparam int SI_BITS  = 17;  // register width, bit 16 is the timer bit
    localparam int SI_LVL_W = 4;   // interrupt level width
    localparam int SI_FIXED = 14;  // level bound for the two fixed-rule bits

    typedef logic [SI_BITS-1:0]  si_vec_t;
    typedef logic [SI_LVL_W-1:0] si_lvl_t;

    typedef enum logic [1:0] {
        SI_OP_HOLD   = 2'd0,
        SI_OP_DIRECT = 2'd1,
        SI_OP_CLEAR  = 2'd2,
        SI_OP_SET    = 2'd3
    } si_op_e;
endpackage

// File: rtl/softint_update.sv
// Module: softint_update
// Works out the next register value from the software write strobes and
// the timer set pulse. Assumes at most one software strobe is meant per
// cycle; simultaneous strobes resolve direct, then clear, then set. The
// timer pulse is ORed in last, so it overrides any clear of its bit.
module softint_update #(
    parameter int W       = 17,
    parameter int TICK_IX = 16
) (
    input  logic [W-1:0] cur_value,
    input  logic         wr_direct,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wr_data,
    input  logic         tick_set,
    output logic [W-1:0] next_value
);
    import softint_pkg::*;

    si_op_e      op;
    logic [W-1:0] sw_value;
    logic [W-1:0] tick_mask;

    // pick the active software operation by fixed priority
    always_comb begin
        if (wr_direct)   op = SI_OP_DIRECT;
        else if (wr_clr) op = SI_OP_CLEAR;
        else if (wr_set) op = SI_OP_SET;
        else             op = SI_OP_HOLD;
    end

    // apply the chosen operation to the current value
    always_comb begin
        unique case (op)
            SI_OP_DIRECT: sw_value = wr_data;
            SI_OP_CLEAR:  sw_value = cur_value & ~wr_data;
            SI_OP_SET:    sw_value = cur_value | wr_data;
            default:      sw_value = cur_value;
        endcase
    end

    // build the one-hot timer bit mask
    always_comb begin
        tick_mask          = '0;
        tick_mask[TICK_IX] = tick_set;
    end

    // merge the timer pulse after the software result
    always_comb next_value = sw_value | tick_mask;
endmodule

// File: rtl/softint_mask.sv
// Module: softint_mask
// Turns a register value and an interrupt level into a request vector.
// Bits listed as fixed-rule (bit 0 and the top bit) pass while the level
// is below FIXED_LVL; every other bit n passes when n exceeds the level.
// Purely combinational.
module softint_mask #(
    parameter int W         = 17,
    parameter int LVL_W     = 4,
    parameter int FIXED_LVL = 14
) (
    input  logic [W-1:0]     value,
    input  logic [LVL_W-1:0] level,
    output logic [W-1:0]     req
);
    localparam int TOP = W - 1;

    for (genvar n = 0; n < W; n++) begin : g_bit
        if (n == 0 || n == TOP) begin : g_fixed
            // fixed threshold rule for the edge bits
            always_comb req[n] = value[n] && (int'(level) < FIXED_LVL);
        end else begin : g_index
            // per-index compare rule for the middle bits
            always_comb req[n] = value[n] && (n > int'(level));
        end
    end
endmodule

// File: rtl/softint_pil_unit.sv
// Module: softint_pil_unit (top)
// Holds the software interrupt register and the interrupt level, and
// registers the masked pending vector. The pending flops load the mask of
// the values being committed on the same edge, so the pending vector
// always matches the stored register and level. Synchronous active-low
// reset clears all state.
module softint_pil_unit #(
    parameter int W         = softint_pkg::SI_BITS,
    parameter int LVL_W     = softint_pkg::SI_LVL_W,
    parameter int FIXED_LVL = softint_pkg::SI_FIXED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_direct,
    input  logic             wr_set,
    input  logic             wr_clr,
    input  logic [W-1:0]     wr_data,
    input  logic             tick_set,
    input  logic             pil_wr,
    input  logic [LVL_W-1:0] pil_data,
    output logic [W-1:0]     rd_value,
    output logic [LVL_W-1:0] pil_value,
    output logic [W-1:0]     pend,
    output logic             any_pend
);
    localparam int TICK_IX = W - 1;

    logic [W-1:0]     reg_q;
    logic [W-1:0]     reg_d;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] lvl_d;
    logic [W-1:0]     req_d;
    logic [W-1:0]     pend_q;
    logic             any_q;

    softint_update #(.W(W), .TICK_IX(TICK_IX)) u_update (
        .cur_value (reg_q),
        .wr_direct (wr_direct),
        .wr_set    (wr_set),
        .wr_clr    (wr_clr),
        .wr_data   (wr_data),
        .tick_set  (tick_set),
        .next_value(reg_d)
    );

    // select the next interrupt level
    always_comb lvl_d = pil_wr ? pil_data : lvl_q;

    softint_mask #(.W(W), .LVL_W(LVL_W), .FIXED_LVL(FIXED_LVL)) u_mask (
        .value(reg_d),
        .level(lvl_d),
        .req  (req_d)
    );

    // commit register, level, pending vector and summary flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q  <= '0;
            lvl_q  <= '0;
            pend_q <= '0;
            any_q  <= 1'b0;
        end else begin
            reg_q  <= reg_d;
            lvl_q  <= lvl_d;
            pend_q <= req_d;
            any_q  <= |req_d;
        end
    end

    assign rd_value  = reg_q;
    assign pil_value = lvl_q;
    assign pend      = pend_q;
    assign any_pend  = any_q;

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && !wr_direct && !wr_clr) |=>
            ((rd_value | {1'b1, {(W-1){1'b0}}}) ==
             (($past(rd_value) | $past(wr_data)) | {1'b1, {(W-1){1'b0}}})));

    // R4
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !wr_direct && !tick_set) |=>
            (rd_value == ($past(rd_value) & ~$past(wr_data))));

    // R5
    tick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_set |=> rd_value[TICK_IX]);

    // R6
    fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(pil_value) >= FIXED_LVL) |-> (!pend[0] && !pend[TICK_IX]));

    // R7
    low_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pil_value == '0) |-> (pend[W-2:1] == rd_value[W-2:1]));

    // R9
    any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend == (pend != '0));

    // R10
    pend_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~rd_value) == '0);
endmodule

// File: tb/softint_pil_unit_tb.sv
// Bench: behavioural reference model of the register, level and mask,
// compared against the outputs on every clock.
module softint_pil_unit_tb_top;
    localparam int W = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_direct = 0, wr_set = 0, wr_clr = 0, tick_set = 0, pil_wr = 0;
    logic [16:0] wr_data = '0;
    logic [3:0]  pil_data = '0;
    logic [16:0] rd_value, pend;
    logic [3:0]  pil_value;
    logic        any_pend;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    int unsigned m_reg = 0;
    int          m_lvl = 0;

    always #4 clk = ~clk;  // 125 MHz

    softint_pil_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_direct(wr_direct), .wr_set(wr_set),
        .wr_clr(wr_clr), .wr_data(wr_data), .tick_set(tick_set),
        .pil_wr(pil_wr), .pil_data(pil_data), .rd_value(rd_value),
        .pil_value(pil_value), .pend(pend), .any_pend(any_pend)
    );

    function automatic int unsigned model_pend(int unsigned v, int lvl);
        int unsigned r = 0;
        for (int n = 0; n < 17; n++) begin
            bit on = ((v >> n) & 1) != 0;
            bit ok = (n == 0 || n == 16) ? (lvl < 14) : (n > lvl);
            if (on && ok) r |= (1 << n);
        end
        return r;
    endfunction

    task automatic check(string req, int unsigned act, int unsigned exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        int unsigned ep = model_pend(m_reg, m_lvl);
        check({tag, " R10 value"}, rd_value, m_reg);
        check({tag, " R8 level"}, pil_value, m_lvl);
        check({tag, " R6/R7 pend"}, pend, ep);
        check({tag, " R9 any"}, any_pend, (ep != 0));
    endtask

    // one cycle: drive at negedge, update model at posedge, compare at negedge
    task automatic step(bit d, bit s, bit c, bit t, int unsigned data,
                        bit pw, int lvl, string tag);
        int unsigned nv;
        wr_direct = d; wr_set = s; wr_clr = c; tick_set = t;
        wr_data = data[16:0]; pil_wr = pw; pil_data = lvl[3:0];
        @(posedge clk);
        if (d)      nv = data & 32'h1FFFF;
        else if (c) nv = m_reg & ~data & 32'h1FFFF;
        else if (s) nv = (m_reg | data) & 32'h1FFFF;
        else        nv = m_reg;
        if (t) nv |= 32'h10000;
        m_reg = nv;
        if (pw) m_lvl = lvl & 15;
        @(negedge clk);
        wr_direct = 0; wr_set = 0; wr_clr = 0; tick_set = 0; pil_wr = 0;
        compare_all(tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        compare_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1 idle");

        // R2: direct write replaces
        step(1,0,0,0, 32'h0A5A5, 0,0, "R2 direct");
        step(1,0,0,0, 32'h15A5A, 0,0, "R2 replace");
        // R3: set alias ORs
        step(0,1,0,0, 32'h00101, 0,0, "R3 set");
        // R4: clear alias removes
        step(0,0,1,0, 32'h05A50, 0,0, "R4 clear");
        // R4: clear beats set
        step(0,1,1,0, 32'h000F0, 0,0, "R4 clr_over_set");
        // R2: direct beats clear and set
        step(1,1,1,0, 32'h1FFFF, 0,0, "R2 priority");

        // R8/R6/R7: level sweep with all bits set
        for (int l = 0; l < 16; l++) step(0,0,0,0, 0, 1,l, "R8 sweep");
        for (int l = 15; l >= 0; l--) step(0,0,0,0, 0, 1,l, "R7 sweep_down");

        // R5: tick against clear and against direct zero
        step(0,0,1,1, 32'h1FFFF, 0,0, "R5 tick_vs_clr");
        step(1,0,0,1, 32'h00000, 0,0, "R5 tick_vs_direct");
        step(0,0,1,0, 32'h10000, 1,14, "R6 clr_top");
        step(0,0,0,1, 0, 0,0, "R6 tick_lvl14");
        step(0,0,0,0, 0, 1,13, "R6 lvl13");
        // R9: write and level change in the same cycle
        step(1,0,0,0, 32'h00001, 1,15, "R9 combined");

        // random phase
        for (int i = 0; i < 3000; i++) begin
            int unsigned r = $urandom;
            step(r[0] & r[1] & r[2], r[3], r[4] & r[5], r[6] & r[7],
                 $urandom, r[8] & r[9], int'(r[13:10]), "R9 random");
        end

        // R1: reset in the middle of activity
        rst_n = 1'b0;
        @(posedge clk); m_reg = 0; m_lvl = 0;
        @(negedge clk);
        compare_all("R1 rereset");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule